// File: doc/BRIEF.md
# Transmit Ordering Scheduler for Posted, Non-Posted and Response Traffic

This block holds three descriptor queues, one each for posted, non-posted and response packets. It picks which queue drives the single transmit port next. A packet is a run of beats that ends with an end-of-packet beat. Within one queue, beats leave in the order they were written. Across queues, a round-robin arbiter chooses among the heads that are allowed to go.

A non-posted or response packet whose pass-posted attribute is clear may not leave before a posted packet that was written earlier. To enforce this, every beat is tagged at write time with a running count of complete posted packets written so far. A blocked head becomes eligible once the count of posted packets fully sent reaches its tag. A head with pass-posted set ignores this limit. Once the first beat of a packet is accepted, its queue keeps the grant until the end-of-packet beat is accepted.

Top module: `tx_order_sched`

## Requirements
- R1: Beats leave each queue in exactly the order they were accepted on that queue's write port.
- R2: A non-posted packet with pass-posted clear is never granted before every posted packet whose end-of-packet beat was written in an earlier cycle than the non-posted packet's first beat has been fully sent.
- R3: A response packet with pass-posted clear obeys the same rule as R2 with respect to earlier posted packets.
- R4: A non-posted or response packet with pass-posted set may be granted ahead of posted packets written before it.
- R5: A posted packet whose end-of-packet beat is written in the same cycle as a non-posted or response first beat does not count as ahead of it.
- R6: Among eligible heads, the grant goes to the first class after the most recently started packet's class, in the cyclic order posted, non-posted, response. After reset, posted is searched first.
- R7: After a non-final beat is accepted, the grant stays on that queue until its end-of-packet beat is accepted. While that queue is empty, `tx_valid` is low and no other queue is granted.
- R8: With no packet in progress and no eligible head, `tx_grant` is zero and `tx_valid` is low.
- R9: A write port's ready is low while its queue holds DEPTH beats. A write offered while ready is low is dropped.
- R10: Synchronous reset empties all queues, clears both packet counters and the lock, and leaves `tx_valid` low and `tx_grant` zero.
- R11: `tx_grant` is one-hot or zero, with bit 0 = posted, bit 1 = non-posted, bit 2 = response. `tx_data` and `tx_eop` are the head beat of the granted queue, and a beat is consumed when `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pst_wr_valid | input | 1 | Posted beat offered |
| pst_wr_ready | output | 1 | Posted queue has space |
| pst_wr_data | input | DW | Posted beat payload |
| pst_wr_eop | input | 1 | Last beat of posted packet |
| npo_wr_valid | input | 1 | Non-posted beat offered |
| npo_wr_ready | output | 1 | Non-posted queue has space |
| npo_wr_data | input | DW | Non-posted beat payload |
| npo_wr_eop | input | 1 | Last beat of non-posted packet |
| npo_wr_pass | input | 1 | Non-posted packet may pass posted traffic |
| rsp_wr_valid | input | 1 | Response beat offered |
| rsp_wr_ready | output | 1 | Response queue has space |
| rsp_wr_data | input | DW | Response beat payload |
| rsp_wr_eop | input | 1 | Last beat of response packet |
| rsp_wr_pass | input | 1 | Response packet may pass posted traffic |
| tx_valid | output | 1 | Granted head beat present |
| tx_ready | input | 1 | Transmit side takes the beat |
| tx_data | output | DW | Transmitted beat payload |
| tx_eop | output | 1 | Transmitted beat ends its packet |
| tx_grant | output | 3 | One-hot granted class |

## Verification
The bench builds the block with DW=8 and DEPTH=4. The 4-beat queues let a short burst fill a queue, so the full and dropped-write behaviour can be exercised. The tag counters are then 4 bits wide, so about twenty posted packets push them through wraparound before a blocking test runs again. This exercises the modular age comparison rather than a plain magnitude test. Hold-off and release of the transmit side set up each ordering case, with the round-robin pointer placed deliberately beforehand.

// File: rtl/tos_pkg.sv
`timescale 1ns/1ps
package tos_pkg;
  localparam int NCLS    = 3;
  localparam int CLS_PST = 0;
  localparam int CLS_NPO = 1;
  localparam int CLS_RSP = 2;
  localparam int CIW     = 2;

  function automatic logic [CIW-1:0] oh_to_idx(input logic [NCLS-1:0] oh);
    logic [CIW-1:0] r;
    r = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (oh[i]) r = CIW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/tos_fifo.sv
`timescale 1ns/1ps
module tos_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_wr, do_rd;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
    end
  end

  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (AW+1)'(wp - rp) <= (AW+1)'(DEPTH));

  assert_fifo_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> (wp == $past(wp)));

  assert_fifo_order_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> (rp == $past(rp) + 1'b1));
endmodule

// File: rtl/tos_elig.sv
`timescale 1ns/1ps
module tos_elig #(
  parameter int CW = 6
) (
  input  logic          head_valid,
  input  logic          head_pass,
  input  logic [CW-1:0] head_stamp,
  input  logic [CW-1:0] pst_sent,
  output logic          eligible
);
  logic signed [CW-1:0] lead;

  assign lead     = head_stamp - pst_sent;
  assign eligible = head_valid && (head_pass || (lead <= 0));
endmodule

// File: rtl/tos_rr_arb.sv
`timescale 1ns/1ps
module tos_rr_arb #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [N-1:0]  gnt
);
  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = int'(last) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assert_arb_pick_R6: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> ($onehot(gnt) && ((gnt & req) == gnt)));
endmodule

// File: rtl/tx_order_sched.sv
`timescale 1ns/1ps
module tx_order_sched
  import tos_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pst_wr_valid,
  output logic          pst_wr_ready,
  input  logic [DW-1:0] pst_wr_data,
  input  logic          pst_wr_eop,
  input  logic          npo_wr_valid,
  output logic          npo_wr_ready,
  input  logic [DW-1:0] npo_wr_data,
  input  logic          npo_wr_eop,
  input  logic          npo_wr_pass,
  input  logic          rsp_wr_valid,
  output logic          rsp_wr_ready,
  input  logic [DW-1:0] rsp_wr_data,
  input  logic          rsp_wr_eop,
  input  logic          rsp_wr_pass,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_eop,
  output logic [2:0]    tx_grant
);
  localparam int CW     = $clog2(DEPTH) + 2;
  localparam int DESC_W = CW + 2 + DW;

  logic [NCLS-1:0] wr_v, wr_e, wr_p, full, empty, elig, rd_en, pick, grant;
  logic [DW-1:0]   wr_d       [NCLS];
  logic [DW-1:0]   head_data  [NCLS];
  logic            head_eop   [NCLS];
  logic            head_pass  [NCLS];
  logic [CW-1:0]   head_stamp [NCLS];

  logic [CW-1:0]   pst_wr_cnt, pst_tx_cnt;
  logic            lock_q;
  logic [CIW-1:0]  lock_idx, last_q, sel_idx;
  logic            accept;

  assign wr_v = {rsp_wr_valid, npo_wr_valid, pst_wr_valid};
  assign wr_e = {rsp_wr_eop, npo_wr_eop, pst_wr_eop};
  assign wr_p = {rsp_wr_pass, npo_wr_pass, 1'b1};
  assign wr_d[CLS_PST] = pst_wr_data;
  assign wr_d[CLS_NPO] = npo_wr_data;
  assign wr_d[CLS_RSP] = rsp_wr_data;

  assign pst_wr_ready = !full[CLS_PST];
  assign npo_wr_ready = !full[CLS_NPO];
  assign rsp_wr_ready = !full[CLS_RSP];

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    logic [DESC_W-1:0] wdesc, rdesc;

    assign wdesc = {pst_wr_cnt, wr_p[g], wr_e[g], wr_d[g]};

    tos_fifo #(.W(DESC_W), .DEPTH(DEPTH)) u_q (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_v[g]),
      .wr_data (wdesc),
      .full    (full[g]),
      .rd_en   (rd_en[g]),
      .rd_data (rdesc),
      .empty   (empty[g])
    );

    assign head_data[g]  = rdesc[DW-1:0];
    assign head_eop[g]   = rdesc[DW];
    assign head_pass[g]  = rdesc[DW+1];
    assign head_stamp[g] = rdesc[DESC_W-1 -: CW];

    tos_elig #(.CW(CW)) u_elig (
      .head_valid (!empty[g]),
      .head_pass  (head_pass[g]),
      .head_stamp (head_stamp[g]),
      .pst_sent   (pst_tx_cnt),
      .eligible   (elig[g])
    );
  end

  tos_rr_arb #(.N(NCLS), .IW(CIW)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (elig),
    .last (last_q),
    .gnt  (pick)
  );

  always_comb begin
    if (lock_q) grant = NCLS'(1) << lock_idx;
    else        grant = pick;
  end

  assign sel_idx  = oh_to_idx(grant);
  assign tx_grant = grant;
  assign tx_valid = |(grant & ~empty);
  assign accept   = tx_valid && tx_ready;
  assign rd_en    = accept ? grant : '0;

  always_comb begin
    tx_data = '0;
    tx_eop  = 1'b0;
    for (int i = 0; i < NCLS; i++) begin
      if (grant[i]) begin
        tx_data = head_data[i];
        tx_eop  = head_eop[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pst_wr_cnt <= '0;
      pst_tx_cnt <= '0;
      lock_q     <= 1'b0;
      lock_idx   <= '0;
      last_q     <= CIW'(CLS_RSP);
    end else begin
      if (pst_wr_valid && pst_wr_ready && pst_wr_eop) pst_wr_cnt <= pst_wr_cnt + 1'b1;
      if (accept) begin
        lock_q   <= !tx_eop;
        lock_idx <= sel_idx;
        if (!lock_q) last_q <= sel_idx;
        if (tx_eop && grant[CLS_PST]) pst_tx_cnt <= pst_tx_cnt + 1'b1;
      end
    end
  end

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_grant));

  assert_npo_order_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !lock_q && grant[CLS_NPO] && !head_pass[CLS_NPO])
      |-> ($signed(CW'(pst_tx_cnt - head_stamp[CLS_NPO])) >= 0));

  assert_rsp_order_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !lock_q && grant[CLS_RSP] && !head_pass[CLS_RSP])
      |-> ($signed(CW'(pst_tx_cnt - head_stamp[CLS_RSP])) >= 0));

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(accept && !tx_eop)) |-> (tx_grant == $past(tx_grant)));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && (elig == '0)) |-> ((tx_grant == '0) && !tx_valid));

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && (tx_grant == '0)));
endmodule

// File: tb/tx_order_sched_tb.sv
`timescale 1ns/1ps
module tx_order_sched_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pst_wr_valid = 0, pst_wr_eop = 0;
  logic npo_wr_valid = 0, npo_wr_eop = 0, npo_wr_pass = 0;
  logic rsp_wr_valid = 0, rsp_wr_eop = 0, rsp_wr_pass = 0;
  logic [DW-1:0] pst_wr_data = '0, npo_wr_data = '0, rsp_wr_data = '0;
  logic pst_wr_ready, npo_wr_ready, rsp_wr_ready;
  logic tx_valid, tx_eop;
  logic tx_ready = 1'b0;
  logic [DW-1:0] tx_data;
  logic [2:0] tx_grant;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] got_d [64];
  logic [2:0] got_g [64];
  int n_got = 0;
  logic [7:0] exp_d [16];
  logic [2:0] exp_g [16];
  int exp_n = 0;

  always #2.5 clk = ~clk;

  tx_order_sched #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .pst_wr_valid(pst_wr_valid), .pst_wr_ready(pst_wr_ready),
    .pst_wr_data(pst_wr_data), .pst_wr_eop(pst_wr_eop),
    .npo_wr_valid(npo_wr_valid), .npo_wr_ready(npo_wr_ready),
    .npo_wr_data(npo_wr_data), .npo_wr_eop(npo_wr_eop), .npo_wr_pass(npo_wr_pass),
    .rsp_wr_valid(rsp_wr_valid), .rsp_wr_ready(rsp_wr_ready),
    .rsp_wr_data(rsp_wr_data), .rsp_wr_eop(rsp_wr_eop), .rsp_wr_pass(rsp_wr_pass),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_eop(tx_eop), .tx_grant(tx_grant)
  );

  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready && n_got < 64) begin
      got_d[n_got] = tx_data;
      got_g[n_got] = tx_grant;
      n_got = n_got + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] g);
    exp_d[exp_n] = d;
    exp_g[exp_n] = g;
    exp_n++;
  endtask

  task automatic expect_seq(input string req);
    check({req, " count"}, n_got, exp_n);
    for (int i = 0; i < exp_n && i < n_got; i++) begin
      check({req, " data"}, got_d[i], exp_d[i]);
      check({req, " grant"}, got_g[i], exp_g[i]);
    end
    exp_n = 0;
  endtask

  task automatic wr(input int cls, input logic [7:0] d, input logic eop, input logic pass);
    @(posedge clk); #1;
    case (cls)
      0: begin pst_wr_valid = 1; pst_wr_data = d; pst_wr_eop = eop; end
      1: begin npo_wr_valid = 1; npo_wr_data = d; npo_wr_eop = eop; npo_wr_pass = pass; end
      default: begin rsp_wr_valid = 1; rsp_wr_data = d; rsp_wr_eop = eop; rsp_wr_pass = pass; end
    endcase
    @(posedge clk); #1;
    pst_wr_valid = 0; npo_wr_valid = 0; rsp_wr_valid = 0;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1;
    tx_ready = v;
  endtask

  task automatic drain(input int cyc);
    set_ready(1);
    repeat (cyc) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 valid after reset", tx_valid, 0);
    check("R10 grant after reset", tx_grant, 0);
    check("R10 queues empty after reset", {pst_wr_ready, npo_wr_ready, rsp_wr_ready}, 3'b111);
  endtask

  task automatic t_round_robin();
    set_ready(0); n_got = 0;
    wr(0, 8'h11, 1, 1); wr(0, 8'h12, 1, 1);
    wr(1, 8'h21, 1, 1);
    wr(2, 8'h31, 1, 1); wr(2, 8'h32, 1, 1);
    drain(10);
    push(8'h11, 3'b001); push(8'h21, 3'b010); push(8'h31, 3'b100);
    push(8'h12, 3'b001); push(8'h32, 3'b100);
    expect_seq("R6 R1 R11 round robin");
  endtask

  task automatic t_blocking();
    set_ready(0); n_got = 0;
    wr(0, 8'h41, 1, 1); wr(0, 8'h42, 1, 1);
    wr(1, 8'h51, 1, 0);
    wr(2, 8'h61, 1, 0);
    drain(10);
    push(8'h41, 3'b001); push(8'h42, 3'b001);
    push(8'h51, 3'b010); push(8'h61, 3'b100);
    expect_seq("R2 R3 blocked behind posted");
  endtask

  task automatic t_hold();
    set_ready(1); n_got = 0;
    @(negedge clk);
    check("R8 idle grant", tx_grant, 0);
    check("R8 idle valid", tx_valid, 0);
    wr(0, 8'h80, 0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 mid-packet valid", tx_valid, 0);
    check("R7 mid-packet grant", tx_grant, 3'b001);
    wr(2, 8'h90, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 other queue held off valid", tx_valid, 0);
    check("R7 other queue held off grant", tx_grant, 3'b001);
    wr(0, 8'h81, 1, 1);
    repeat (6) @(posedge clk);
    push(8'h80, 3'b001); push(8'h81, 3'b001); push(8'h90, 3'b100);
    expect_seq("R7 grant held to eop");
    @(negedge clk);
    check("R8 idle after drain grant", tx_grant, 0);
    check("R8 idle after drain valid", tx_valid, 0);
  endtask

  task automatic t_pass();
    set_ready(1); n_got = 0;
    wr(0, 8'h9F, 1, 1);
    repeat (3) @(posedge clk);
    set_ready(0);
    wr(0, 8'hA0, 1, 1);
    wr(1, 8'hA1, 1, 1);
    wr(2, 8'hA2, 1, 0);
    drain(10);
    push(8'h9F, 3'b001); push(8'hA1, 3'b010);
    push(8'hA0, 3'b001); push(8'hA2, 3'b100);
    expect_seq("R4 pass-posted overtakes");
  endtask

  task automatic t_same_cycle();
    set_ready(1); n_got = 0;
    wr(0, 8'hAF, 1, 1);
    repeat (3) @(posedge clk);
    set_ready(0);
    @(posedge clk); #1;
    pst_wr_valid = 1; pst_wr_data = 8'hB0; pst_wr_eop = 1;
    npo_wr_valid = 1; npo_wr_data = 8'hB1; npo_wr_eop = 1; npo_wr_pass = 0;
    @(posedge clk); #1;
    pst_wr_valid = 0; npo_wr_valid = 0;
    drain(8);
    push(8'hAF, 3'b001); push(8'hB1, 3'b010); push(8'hB0, 3'b001);
    expect_seq("R5 same-cycle posted not ahead");
  endtask

  task automatic t_full();
    set_ready(0); n_got = 0;
    for (int k = 0; k < 4; k++) wr(0, 8'hC0 + 8'(k), 1, 1);
    @(negedge clk);
    check("R9 posted ready low when full", pst_wr_ready, 0);
    check("R9 other queue ready", npo_wr_ready, 1);
    wr(0, 8'hC4, 1, 1);
    drain(10);
    push(8'hC0, 3'b001); push(8'hC1, 3'b001);
    push(8'hC2, 3'b001); push(8'hC3, 3'b001);
    expect_seq("R9 R1 write to full queue dropped");
    @(negedge clk);
    check("R9 queue empty after drain", tx_valid, 0);
  endtask

  task automatic t_wrap();
    set_ready(1);
    for (int k = 0; k < 20; k++) wr(0, 8'hE0 + 8'(k), 1, 1);
    repeat (4) @(posedge clk);
    set_ready(0); n_got = 0;
    wr(0, 8'hD0, 1, 1);
    wr(1, 8'hD1, 1, 0);
    wr(2, 8'hD2, 1, 0);
    drain(10);
    push(8'hD0, 3'b001); push(8'hD1, 3'b010); push(8'hD2, 3'b100);
    expect_seq("R2 R3 blocking after counter wrap");
  endtask

  task automatic t_mid_reset();
    set_ready(0);
    wr(0, 8'hF0, 1, 1);
    @(negedge clk);
    check("R11 valid with head present", tx_valid, 1);
    @(posedge clk); #1 rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R10 valid after mid reset", tx_valid, 0);
    check("R10 grant after mid reset", tx_grant, 0);
    n_got = 0;
    drain(4);
    check("R10 queue cleared by reset", n_got, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_round_robin();
    t_blocking();
    t_hold();
    t_pass();
    t_same_cycle();
    t_full();
    t_wrap();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule